// File: doc/BRIEF.md
# Dibit Stream Byte and Block Synchronizer

This block sits at the front of a broadcast transport decoder. It receives a serial symbol stream of two bits per clock, together with a per-clock qualifier. It finds the byte boundaries from the data alone and locks onto the fixed 204-byte block structure. Each block opens with one sync byte. That byte is normally 47h, and once per eight-block frame it is the inverted value B8h. Either value counts as a valid sync.

While out of sync, the block checks every incoming valid dibit to see whether the last four dibits form a sync byte. This tests each of the four possible byte phases in turn. The first candidate freezes the phase and starts a byte counter. After that, a byte strobe is issued every fourth valid dibit, and the sync position is checked once per 204 bytes. A confidence state machine climbs from 0 to 6 on consecutive good syncs. The not-synchronized flag clears only at the top state. When fully locked, a single missing sync only lowers the state by one, so one corrupted header does not drop lock. Downstream logic, such as a de-interleaver, consumes the aligned bytes, the byte strobe and a block-start flag that is qualified by lock.

Top module: `blk_sync_top`

## Requirements
- R1: Each output byte is built from four valid dibits, and the earliest dibit forms bits 7:6 (MSB first).
- R2: Input cycles with `sym_vld` low are ignored whatever `sym_in` carries, and any pattern of gaps yields the same byte stream.
- R3: While hunting, a sync value is detected at any of the four dibit offsets. That byte is emitted with a strobe, and it becomes byte 0 of a block.
- R4: Both 47h and B8h are accepted as sync bytes, in any mix.
- R5: Once framed, a strobe occurs on every fourth valid dibit and never on two adjacent cycles. The sync position repeats every 204 bytes.
- R6: `no_lock` stays 1 until six consecutive syncs have been seen at 204-byte spacing. It drops to 0 in the cycle that strobes the sixth sync.
- R7: In confidence states 1 to 5, a wrong byte at the sync position returns the block to hunting. That byte gets no strobe.
- R8: At full lock, one wrong sync raises `no_lock` but strobes continue. The next correct sync restores lock, and a second consecutive miss returns the block to hunting.
- R9: `blk_start` is high only together with the strobe of a sync byte while `no_lock` is 0.
- R10: A synchronous active-high reset clears the phase, byte and state counters. It sets `byte_stb`=0, `blk_start`=0 and `no_lock`=1, and hunting restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; symbols are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_in | input | 2 | Two stream bits; bit 1 is the earlier one |
| sym_vld | input | 1 | Qualifies `sym_in` in this cycle |
| byte_out | output | 8 | Aligned byte, valid while `byte_stb` is high |
| byte_stb | output | 1 | One-cycle strobe for each aligned byte |
| blk_start | output | 1 | Marks the sync byte of a block while locked |
| no_lock | output | 1 | 1 while the block structure is not fully confirmed |

## Verification
The sixth consecutive sync check and the block-start strobe resolve on the same clock edge. The bench therefore confirms that `no_lock` falls in exactly the cycle whose strobe carries `blk_start`, and never one strobe earlier or later. The reverse case is a single missed sync at full lock. There, `no_lock` rises while the strobe of the corrupted header still appears without `blk_start`. Both cases are provoked by whole-block sequences with chosen headers, one of them with irregular valid gaps. Each strobe is logged with its flags, and the bench judges the flags at computed block offsets.

// File: rtl/blk_sync_pkg.sv
package blk_sync_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_MAIN  = 8'h47;
  localparam logic [BYTE_W-1:0] SYNC_FRAME = 8'hB8;

  function automatic logic is_sync(input logic [BYTE_W-1:0] b);
    return (b == SYNC_MAIN) || (b == SYNC_FRAME);
  endfunction
endpackage

// File: rtl/sym_packer.sv
module sym_packer #(
  parameter int SYM_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [SYM_W-1:0]  sym,
  output logic [BYTE_W-1:0] window
);
  logic [BYTE_W-1:0] hist;

  // newest symbol enters at the LSB end, so the oldest ends up on top
  always_comb begin
    window = hist;
    if (vld) window = {hist[BYTE_W-SYM_W-1:0], sym};
  end

  always_ff @(posedge clk) begin
    if (rst)      hist <= '0;
    else if (vld) hist <= window;
  end
endmodule

// File: rtl/blk_counter.sv
module blk_counter #(
  parameter int SLOTS     = 4,
  parameter int BLOCK_LEN = 204
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic tracking,
  input  logic restart,
  output logic byte_done,
  output logic at_head
);
  localparam int DW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BW = $clog2(BLOCK_LEN);

  logic [DW-1:0] dcnt;
  logic [BW-1:0] bcnt;

  assign byte_done = step && tracking && (dcnt == DW'(SLOTS - 1));
  assign at_head   = byte_done && (bcnt == BW'(BLOCK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !tracking) begin
      dcnt <= '0;
      bcnt <= '0;
    end else if (step) begin
      if (byte_done) begin
        dcnt <= '0;
        bcnt <= at_head ? '0 : bcnt + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm #(
  parameter int LOCK_RUN = 6,
  parameter int ST_W     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hunt_hit,
  input  logic            head_check,
  input  logic            head_ok,
  output logic [ST_W-1:0] state,
  output logic [ST_W-1:0] nxt
);
  localparam logic [ST_W-1:0] TOP = ST_W'(LOCK_RUN);

  always_comb begin
    nxt = state;
    if (state == '0) begin
      if (hunt_hit) nxt = ST_W'(1);
    end else if (head_check) begin
      if (head_ok)          nxt = (state == TOP) ? TOP : state + 1'b1;
      else if (state == TOP) nxt = TOP - 1'b1;
      else                  nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= nxt;
  end
endmodule

// File: rtl/blk_sync_top.sv
module blk_sync_top
  import blk_sync_pkg::*;
#(
  parameter int SYM_W     = 2,
  parameter int BLOCK_LEN = 204,
  parameter int LOCK_RUN  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  sym_in,
  input  logic              sym_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              blk_start,
  output logic              no_lock
);
  localparam int SLOTS = BYTE_W / SYM_W;
  localparam int ST_W  = $clog2(LOCK_RUN + 1);

  logic [BYTE_W-1:0] window;
  logic [ST_W-1:0]   lock_state, lock_nxt;
  logic              byte_done, at_head;
  logic              hunting, window_sync, hunt_hit, loss, emit, head_emit;

  sym_packer #(.SYM_W(SYM_W), .BYTE_W(BYTE_W)) pack_i (
    .clk(clk), .rst(rst), .vld(sym_vld), .sym(sym_in), .window(window));

  assign hunting     = (lock_state == '0);
  assign window_sync = is_sync(window);
  assign hunt_hit    = hunting && sym_vld && window_sync;

  blk_counter #(.SLOTS(SLOTS), .BLOCK_LEN(BLOCK_LEN)) cnt_i (
    .clk(clk), .rst(rst), .step(sym_vld), .tracking(!hunting),
    .restart(hunt_hit), .byte_done(byte_done), .at_head(at_head));

  lock_fsm #(.LOCK_RUN(LOCK_RUN), .ST_W(ST_W)) fsm_i (
    .clk(clk), .rst(rst), .hunt_hit(hunt_hit), .head_check(at_head),
    .head_ok(window_sync), .state(lock_state), .nxt(lock_nxt));

  assign loss      = at_head && !window_sync && (lock_state != ST_W'(LOCK_RUN));
  assign emit      = hunt_hit || (byte_done && !loss);
  assign head_emit = hunt_hit || (at_head && !loss);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out  <= '0;
      byte_stb  <= 1'b0;
      blk_start <= 1'b0;
      no_lock   <= 1'b1;
    end else begin
      byte_stb  <= emit;
      blk_start <= head_emit && (lock_nxt == ST_W'(LOCK_RUN));
      no_lock   <= (lock_nxt != ST_W'(LOCK_RUN));
      if (emit) byte_out <= window;
    end
  end
endmodule

// File: rtl/blk_sync_chk.sv
module blk_sync_chk #(
  parameter int LOCK_RUN = 6,
  parameter int ST_W     = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            sym_vld,
  input logic [7:0]      byte_out,
  input logic            byte_stb,
  input logic            blk_start,
  input logic            no_lock,
  input logic [ST_W-1:0] state
);
  a_r5_no_adjacent_stb: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);

  a_r2_stb_needs_valid: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> $past(sym_vld));

  a_r9_blk_qualified: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> (byte_stb && !no_lock));

  a_r4_blk_carries_sync: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> (byte_out == 8'h47 || byte_out == 8'hB8));

  a_r6_lock_on_sync_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(no_lock) |-> blk_start);

  a_r8_stepdown_keeps_stb: assert property (@(posedge clk) disable iff (rst)
    $rose(no_lock) |-> (byte_stb && !blk_start));

  a_r6_lock_means_top: assert property (@(posedge clk) disable iff (rst)
    !no_lock |-> (state == ST_W'(LOCK_RUN)));

  a_r7_state_range: assert property (@(posedge clk) disable iff (rst)
    state <= ST_W'(LOCK_RUN));
endmodule

bind blk_sync_top blk_sync_chk #(.LOCK_RUN(LOCK_RUN), .ST_W(ST_W)) chk_i (
  .clk(clk), .rst(rst), .sym_vld(sym_vld), .byte_out(byte_out),
  .byte_stb(byte_stb), .blk_start(blk_start), .no_lock(no_lock),
  .state(lock_state));

// File: tb/blk_sync_top_tb_top.sv
module blk_sync_top_tb_top;
  localparam int BLK = 204;
  localparam int LOG = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sym_in = 2'b00;
  logic       sym_vld = 1'b0;
  logic [7:0] byte_out;
  logic       byte_stb, blk_start, no_lock;

  int n_pass = 0, n_fail = 0;
  int n_stb = 0, n_blk = 0;
  int base = 0, blk_base = 0;
  int gap_on = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] rec_b   [0:LOG-1];
  logic       rec_blk [0:LOG-1];
  logic       rec_nl  [0:LOG-1];

  always #2 clk = ~clk;

  blk_sync_top dut_i (
    .clk(clk), .rst(rst), .sym_in(sym_in), .sym_vld(sym_vld),
    .byte_out(byte_out), .byte_stb(byte_stb), .blk_start(blk_start),
    .no_lock(no_lock));

  always @(negedge clk) begin
    if (!rst && byte_stb) begin
      int k;
      k = n_stb - base;
      if (k >= 0 && k < LOG) begin
        rec_b[k]   = byte_out;
        rec_blk[k] = blk_start;
        rec_nl[k]  = no_lock;
      end
      n_stb = n_stb + 1;
      if (blk_start) n_blk = n_blk + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int j);
    return 8'((j * 29 + 11) & 255);
  endfunction

  task automatic mark();
    base = n_stb;
    blk_base = n_blk;
  endtask

  task automatic put_dibit(input logic [1:0] d);
    int gap;
    gap = 0;
    if (gap_on != 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gap = int'(lfsr[1:0]) % 3;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      sym_vld = 1'b0;
      sym_in  = 2'b11;
    end
    @(negedge clk);
    sym_vld = 1'b1;
    sym_in  = d;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 3; i >= 0; i--) put_dibit(b[2*i +: 2]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sym_vld = 1'b0;
      sym_in  = 2'b00;
    end
  endtask

  task automatic send_block(input logic [7:0] sb, input bit zero_pl);
    put_byte(sb);
    for (int j = 1; j < BLK; j++) put_byte(zero_pl ? 8'h00 : pay(j));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sym_vld = 1'b0;
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    mark();
  endtask

  task automatic payload_mismatch(input int start, output int errs);
    errs = 0;
    for (int j = 1; j < BLK; j++)
      if (rec_b[start + j] !== pay(j)) errs++;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check(byte_stb == 1'b0, "R10 stb after reset", byte_stb, 0);
    check(blk_start == 1'b0, "R10 blk_start after reset", blk_start, 0);
    check(no_lock == 1'b1, "R10 no_lock after reset", no_lock, 1);
  endtask

  task automatic t_lock_main();
    int errs;
    do_reset();
    gap_on = 0;
    put_byte(8'h00); put_byte(8'h00);
    put_dibit(2'b00);
    for (int b = 0; b < 7; b++) send_block(8'h47, 1'b0);
    idle(4);
    check(n_stb - base == 7 * BLK, "R5 strobe count", n_stb - base, 7 * BLK);
    check(rec_b[0] == 8'h47, "R3 first strobe is sync", rec_b[0], 8'h47);
    payload_mismatch(0, errs);
    check(errs == 0, "R1 payload bytes MSB first", errs, 0);
    check(rec_nl[4 * BLK] == 1'b1, "R6 fifth sync still unlocked", rec_nl[4 * BLK], 1);
    check(rec_nl[5 * BLK] == 1'b0 && rec_blk[5 * BLK] == 1'b1,
          "R6 lock with sixth sync strobe", {rec_nl[5 * BLK], rec_blk[5 * BLK]}, 1);
    check(rec_nl[5 * BLK - 1] == 1'b1, "R6 unlocked just before sixth", rec_nl[5 * BLK - 1], 1);
    check(n_blk - blk_base == 2, "R9 block starts only while locked", n_blk - blk_base, 2);
    check(rec_blk[6 * BLK + 1] == 1'b0, "R9 no blk_start on payload", rec_blk[6 * BLK + 1], 0);
  endtask

  task automatic t_frame_sync_gaps();
    int errs;
    do_reset();
    gap_on = 1;
    put_byte(8'h00);
    put_dibit(2'b00); put_dibit(2'b00); put_dibit(2'b00);
    send_block(8'hB8, 1'b0);
    for (int b = 0; b < 5; b++) send_block(8'h47, 1'b0);
    idle(4);
    gap_on = 0;
    check(rec_b[0] == 8'hB8, "R4 B8h accepted in hunt", rec_b[0], 8'hB8);
    check(n_stb - base == 6 * BLK, "R2 strobes with gaps", n_stb - base, 6 * BLK);
    payload_mismatch(2 * BLK, errs);
    check(errs == 0, "R2 gaps leave bytes intact", errs, 0);
    check(rec_nl[5 * BLK] == 1'b0 && rec_b[5 * BLK] == 8'h47,
          "R4 mixed sync values lock", rec_nl[5 * BLK], 0);
  endtask

  task automatic t_early_miss();
    do_reset();
    for (int b = 0; b < 3; b++) send_block(8'h47, 1'b0);
    send_block(8'h00, 1'b1);
    idle(4);
    check(n_stb - base == 3 * BLK, "R7 no strobe after early miss", n_stb - base, 3 * BLK);
    check(no_lock == 1'b1, "R7 still unlocked", no_lock, 1);
    for (int b = 0; b < 6; b++) send_block(8'h47, 1'b0);
    idle(4);
    check(rec_b[3 * BLK] == 8'h47 && rec_nl[3 * BLK] == 1'b1,
          "R7 rehunt restarts count", rec_b[3 * BLK], 8'h47);
    check(n_blk - blk_base == 1, "R7 relock after six new syncs", n_blk - blk_base, 1);
  endtask

  task automatic t_flywheel();
    do_reset();
    for (int b = 0; b < 6; b++) send_block(8'h47, 1'b0);
    send_block(8'h00, 1'b1);
    send_block(8'h47, 1'b0);
    send_block(8'h00, 1'b1);
    send_block(8'h00, 1'b1);
    idle(4);
    check(rec_nl[6 * BLK] == 1'b1 && rec_blk[6 * BLK] == 1'b0,
          "R8 single miss strobed unlocked", rec_nl[6 * BLK], 1);
    check(rec_b[6 * BLK] == 8'h00, "R8 missed header still emitted", rec_b[6 * BLK], 0);
    check(rec_nl[7 * BLK] == 1'b0 && rec_blk[7 * BLK] == 1'b1,
          "R8 lock restored on next sync", rec_nl[7 * BLK], 0);
    check(n_stb - base == 9 * BLK, "R8 second miss returns to hunt", n_stb - base, 9 * BLK);
    check(no_lock == 1'b1, "R8 unlocked at end", no_lock, 1);
  endtask

  task automatic t_reset_midlock();
    do_reset();
    for (int b = 0; b < 6; b++) send_block(8'h47, 1'b0);
    put_byte(8'h12);
    check(no_lock == 1'b0, "R10 locked before reset", no_lock, 0);
    do_reset();
    @(negedge clk);
    check(no_lock == 1'b1 && byte_stb == 1'b0, "R10 reset drops lock", no_lock, 1);
    send_block(8'h00, 1'b1);
    idle(4);
    check(n_stb - base == 0, "R10 hunting after reset", n_stb - base, 0);
    send_block(8'h47, 1'b1);
    idle(4);
    check(rec_b[0] == 8'h47 && rec_nl[0] == 1'b1, "R10 rehunt finds sync", rec_b[0], 8'h47);
  endtask

  initial begin
    t_reset_state();
    t_lock_main();
    t_frame_sync_gaps();
    t_early_miss();
    t_flywheel();
    t_reset_midlock();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end
endmodule